// File: doc/BRIEF.md
# Command-Driven I2C Master Transmitter

This block is an I2C master that only transmits, and software steers it one register write at a time. It has no transaction port. Software selects master operation in a control register and loads a clock divisor. It then requests a START, writes the address byte and each data byte into a transmit register, and finally requests a STOP. After each of these bus events the block raises an interrupt flag. Software clears the flag by writing to a flag-clear location.

SCL and SDA are open-drain lines. The block pulls a line low by asserting its output enable, and it reads the actual line levels back. A quarter-bit timer sets the bit timing. The timer reloads from the low bits of the divisor, and it only counts the high phase while SCL actually reads high. A slave that stretches the clock therefore lengthens that bit. After each byte the block samples the slave's acknowledge and keeps it in a status bit. It also keeps two flags that record whether the last bus condition it produced was a START or a STOP.

Register map on the write port (`reg_addr`): 0 = control, 1 = command, 2 = divisor, 3 = transmit byte, 4 = flag clear.

Top module: `i2cm_top`

## Requirements
- R1: A START request is ignored unless the control register holds enable bit 7 = 1 and mode code bits [3:0] = 4'b1000. When a request is ignored, SCL and SDA stay released and `busy` stays 0.
- R2: Writing command bit 0 while the bus is idle produces a START: SDA falls while SCL is high, then SCL is pulled low. `start_pend` reads 1 until the START completes and then clears itself.
- R3: Writing the transmit register after a START or after a finished byte shifts the 8 bits out MSB first, one per SCL clock. SDA changes only while SCL is low. SDA is released for a ninth clock.
- R4: On the ninth clock the line level is captured into `ack_nak`: 0 means the slave acknowledged, 1 means it did not.
- R5: `irq` is set when a START completes, at the end of the ninth clock of every byte, and when a STOP completes. It stays set until a write to address 4 with bit 0 = 1. If that write falls in the same cycle as a new set, the set wins.
- R6: Writing command bit 2 while the block is holding the bus between bytes produces a STOP: SDA rises while SCL is high. Afterwards `stop_seen` = 1, `start_seen` = 0, and both lines are released.
- R7: The SCL period is 4 × (D + 1) clock cycles. D is the low 7 bits of the divisor register, and bit 7 is ignored (a write of 200 gives D = 72).
- R8: A divisor whose low 7 bits are 0, 1 or 2 is treated as 3, so the SCL period is 16 cycles.
- R9: The high-phase timer starts only once SCL reads high. A slave holding SCL low for S extra cycles lengthens that SCL period to 4 × (D + 1) + S.
- R10: A write to the transmit register while a byte is shifting sets `wcol` and is discarded; the byte on the bus is unchanged. A write to address 4 with bit 1 = 1 clears `wcol`.
- R11: A START request while the bus is held, a STOP request while a byte is shifting, and a transmit write while idle are all ignored. None of them changes the bus or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Event flag |
| ack_nak | output | 1 | Acknowledge of the last byte (1 = no acknowledge) |
| start_seen | output | 1 | The last condition produced was a START |
| stop_seen | output | 1 | The last condition produced was a STOP |
| wcol | output | 1 | Transmit write collided with a byte in progress |
| busy | output | 1 | The block owns the bus or is producing a condition |
| start_pend | output | 1 | START request in progress |
| stop_pend | output | 1 | STOP request in progress |

## Verification
Two events can land in the same clock cycle: the hardware setting `irq` at the end of a byte, and a software write that clears it. The bench provokes this by holding a flag-clear write on the port for every cycle of a byte transfer. Because the set must win, `irq` has to be seen high for at least one cycle before the held clear removes it. If the clear won instead, `irq` would never be seen and the wait would time out as a failure.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [2:0] {E_IDLE, E_START, E_HOLD, E_BIT, E_STOP} eng_state_t;

   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_CMD  = 3'd1;
   localparam logic [2:0] RA_DIV  = 3'd2;
   localparam logic [2:0] RA_TX   = 3'd3;
   localparam logic [2:0] RA_CLR  = 3'd4;

   localparam logic [3:0] MODE_MASTER = 4'b1000;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs #(
   parameter int DW      = 8,
   parameter int MIN_DIV = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [2:0]      addr_i,
   input  logic [DW-1:0]   wdata_i,
   output logic            mode_ok_o,
   output logic [DW-2:0]   reload_o,
   output logic            start_cmd_o,
   output logic            stop_cmd_o,
   output logic            tx_wr_o,
   output logic [7:0]      tx_data_o,
   output logic            clr_irq_o,
   output logic            clr_wcol_o
);
   import i2cm_pkg::*;
   localparam int RLD_W = DW - 1;
   localparam logic [RLD_W-1:0] MIN_R = RLD_W'(MIN_DIV);

   logic             en_q;
   logic [3:0]       mode_q;
   logic [RLD_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= '0;
         div_q  <= '1;
      end else if (we_i) begin
         if (addr_i == RA_CTRL) begin
            en_q   <= wdata_i[DW-1];
            mode_q <= wdata_i[3:0];
         end
         if (addr_i == RA_DIV) div_q <= wdata_i[RLD_W-1:0];
      end
   end

   assign mode_ok_o   = en_q && (mode_q == MODE_MASTER);
   assign reload_o    = (div_q < MIN_R) ? MIN_R : div_q;
   assign start_cmd_o = we_i && (addr_i == RA_CMD) && wdata_i[0];
   assign stop_cmd_o  = we_i && (addr_i == RA_CMD) && wdata_i[2];
   assign tx_wr_o     = we_i && (addr_i == RA_TX);
   assign tx_data_o   = wdata_i[7:0];
   assign clr_irq_o   = we_i && (addr_i == RA_CLR) && wdata_i[0];
   assign clr_wcol_o  = we_i && (addr_i == RA_CLR) && wdata_i[1];
endmodule

// File: rtl/i2cm_brg.sv
module i2cm_brg #(
   parameter int RLD_W   = 7,
   parameter int MIN_DIV = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             hold_i,
   input  logic [RLD_W-1:0] reload_i,
   output logic             tick_o
);
   localparam logic [RLD_W-1:0] MIN_R = RLD_W'(MIN_DIV);

   logic [RLD_W-1:0] cnt_q;

   assign tick_o = run_i && !hold_i && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (!run_i || hold_i || tick_o) cnt_q <= reload_i;
      else                                 cnt_q <= cnt_q - RLD_W'(1);
   end

   // R9: a stretched (low) SCL keeps the timer parked at its reload value
   assert_stretch_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && hold_i) |=> cnt_q == $past(reload_i));
   // R8: the divisor reaching the timer never falls below the floor
   assert_reload_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i >= MIN_R);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_ok_i,
   input  logic       start_cmd_i,
   input  logic       stop_cmd_i,
   input  logic       tx_wr_i,
   input  logic [7:0] tx_data_i,
   input  logic       clr_irq_i,
   input  logic       clr_wcol_i,
   input  logic       tick_i,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe_o,
   output logic       sda_oe_o,
   output logic       brg_run_o,
   output logic       brg_hold_o,
   output logic       irq_o,
   output logic       nak_o,
   output logic       start_seen_o,
   output logic       stop_seen_o,
   output logic       wcol_o,
   output logic       busy_o,
   output logic       start_pend_o,
   output logic       stop_pend_o
);
   import i2cm_pkg::*;

   eng_state_t st_q;
   logic [1:0] q_q;
   logic [3:0] bitn_q;
   logic [7:0] sh_q;
   logic       hold_low_q;

   always_comb begin
      scl_oe_o = 1'b0;
      sda_oe_o = 1'b0;
      unique case (st_q)
         E_START: begin scl_oe_o = (q_q == 2'd2); sda_oe_o = 1'b1; end
         E_HOLD:  begin scl_oe_o = 1'b1;          sda_oe_o = hold_low_q; end
         E_BIT:   begin
            scl_oe_o = (q_q == 2'd0) || (q_q == 2'd3);
            sda_oe_o = (bitn_q < 4'd8) && !sh_q[7];
         end
         E_STOP:  begin scl_oe_o = (q_q == 2'd0); sda_oe_o = (q_q != 2'd2); end
         default: ;
      endcase
   end

   assign brg_run_o    = (st_q == E_START) || (st_q == E_BIT) || (st_q == E_STOP);
   assign brg_hold_o   = !scl_oe_o && !scl_i;
   assign busy_o       = (st_q != E_IDLE);
   assign start_pend_o = (st_q == E_START);
   assign stop_pend_o  = (st_q == E_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= E_IDLE; q_q <= '0; bitn_q <= '0; sh_q <= '0; hold_low_q <= 1'b0;
         irq_o <= 1'b0; nak_o <= 1'b0; wcol_o <= 1'b0;
         start_seen_o <= 1'b0; stop_seen_o <= 1'b0;
      end else begin
         if (clr_irq_i)  irq_o  <= 1'b0;
         if (clr_wcol_i) wcol_o <= 1'b0;
         unique case (st_q)
            E_IDLE: if (start_cmd_i && mode_ok_i) begin
               st_q <= E_START; q_q <= 2'd0;
            end
            E_START: if (tick_i) begin
               if (q_q == 2'd2) begin
                  st_q <= E_HOLD; hold_low_q <= 1'b1; irq_o <= 1'b1;
                  start_seen_o <= 1'b1; stop_seen_o <= 1'b0;
               end else q_q <= q_q + 2'd1;
            end
            E_HOLD: begin
               if (tx_wr_i) begin
                  st_q <= E_BIT; q_q <= 2'd0; bitn_q <= '0; sh_q <= tx_data_i;
               end else if (stop_cmd_i) begin
                  st_q <= E_STOP; q_q <= 2'd0;
               end
            end
            E_BIT: begin
               if (tx_wr_i) wcol_o <= 1'b1;
               if (tick_i) begin
                  q_q <= q_q + 2'd1;
                  if (q_q == 2'd2 && bitn_q == 4'd8) nak_o <= sda_i;
                  if (q_q == 2'd3) begin
                     if (bitn_q == 4'd8) begin
                        st_q <= E_HOLD; hold_low_q <= 1'b0; irq_o <= 1'b1;
                     end else begin
                        bitn_q <= bitn_q + 4'd1;
                        sh_q   <= {sh_q[6:0], 1'b0};
                     end
                  end
               end
            end
            E_STOP: if (tick_i) begin
               if (q_q == 2'd2) begin
                  st_q <= E_IDLE; irq_o <= 1'b1;
                  stop_seen_o <= 1'b1; start_seen_o <= 1'b0;
               end else q_q <= q_q + 2'd1;
            end
            default: st_q <= E_IDLE;
         endcase
      end
   end

   // R3: data may only move while SCL is driven low
   assert_sda_quiet_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == E_BIT && !scl_oe_o) |=> (st_q != E_BIT || scl_oe_o || $stable(sda_oe_o)));
   // R5: the flag only rises when a bus event ends
   assert_irq_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(st_q) != st_q);
   // R6: the two condition flags never read 1 together
   assert_cond_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_seen_o && stop_seen_o));
   // R10: a collision is only raised by a buffer write during a byte
   assert_wcol_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcol_o) |-> $past(tx_wr_i && st_q == E_BIT));
   // R11: a START request while holding the bus does not restart
   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == E_HOLD && start_cmd_i) |=> st_q != E_START);
   // R4: the acknowledge status only moves while a byte is shifting
   assert_nak_in_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nak_o) |-> $past(st_q) == E_BIT);
endmodule

// File: rtl/i2cm_top.sv
module i2cm_top #(
   parameter int DW          = 8,
   parameter int MIN_DIV     = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          scl_oe,
   output logic          sda_oe,
   output logic          irq,
   output logic          ack_nak,
   output logic          start_seen,
   output logic          stop_seen,
   output logic          wcol,
   output logic          busy,
   output logic          start_pend,
   output logic          stop_pend
);
   localparam int RLD_W = DW - 1;

   if (DW != 8) begin : g_bad_dw
      $error("i2cm_top: register map needs DW == 8");
   end
   if (MIN_DIV < 1 || MIN_DIV >= (1 << RLD_W)) begin : g_bad_min
      $error("i2cm_top: MIN_DIV out of range");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("i2cm_top: SYNC_STAGES must be >= 0");
   end

   logic scl_s, sda_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign scl_s = scl_in;
      assign sda_s = sda_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] scl_r, sda_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_r <= '1; sda_r <= '1;
         end else begin
            scl_r <= {scl_r, scl_in}[SYNC_STAGES-1:0];
            sda_r <= {sda_r, sda_in}[SYNC_STAGES-1:0];
         end
      end
      assign scl_s = scl_r[SYNC_STAGES-1];
      assign sda_s = sda_r[SYNC_STAGES-1];
   end

   logic             mode_ok, start_cmd, stop_cmd, tx_wr, clr_irq, clr_wcol;
   logic [7:0]       tx_data;
   logic [RLD_W-1:0] reload;
   logic             tick, brg_run, brg_hold;

   i2cm_regs #(.DW(DW), .MIN_DIV(MIN_DIV)) u_regs (
      .clk, .rst_n, .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
      .mode_ok_o(mode_ok), .reload_o(reload), .start_cmd_o(start_cmd),
      .stop_cmd_o(stop_cmd), .tx_wr_o(tx_wr), .tx_data_o(tx_data),
      .clr_irq_o(clr_irq), .clr_wcol_o(clr_wcol));

   i2cm_brg #(.RLD_W(RLD_W), .MIN_DIV(MIN_DIV)) u_brg (
      .clk, .rst_n, .run_i(brg_run), .hold_i(brg_hold), .reload_i(reload),
      .tick_o(tick));

   i2cm_engine u_eng (
      .clk, .rst_n, .mode_ok_i(mode_ok), .start_cmd_i(start_cmd),
      .stop_cmd_i(stop_cmd), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
      .clr_irq_i(clr_irq), .clr_wcol_i(clr_wcol), .tick_i(tick),
      .scl_i(scl_s), .sda_i(sda_s), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
      .brg_run_o(brg_run), .brg_hold_o(brg_hold), .irq_o(irq), .nak_o(ack_nak),
      .start_seen_o(start_seen), .stop_seen_o(stop_seen), .wcol_o(wcol),
      .busy_o(busy), .start_pend_o(start_pend), .stop_pend_o(stop_pend));
endmodule

// File: tb/sim_i2cm_top.sv
module sim_i2cm_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       scl_oe, sda_oe, irq, ack_nak, start_seen, stop_seen;
   logic       wcol, busy, start_pend, stop_pend;
   logic       slave_low = 1'b0, stretch = 1'b0;
   wire        scl_line = !scl_oe && !stretch;
   wire        sda_line = !sda_oe && !slave_low;

   int checks = 0, errors = 0, cyc = 0;
   int starts = 0, stops = 0, bytes_seen = 0, period_c = 0, last_rise = -1;
   int bitcnt = 0, stretch_cnt = 0, stretch_s = 0, qlen = 10;
   bit ack_en = 1'b1, irq_seen = 1'b0;
   logic p_scl = 1'b1, p_sda = 1'b1;
   logic [7:0] rx_sh = '0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   i2cm_top u0 (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
      .scl_in(scl_line), .sda_in(sda_line), .scl_oe, .sda_oe, .irq, .ack_nak,
      .start_seen, .stop_seen, .wcol, .busy, .start_pend, .stop_pend);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_irq(input string tag);
      int i;
      for (i = 0; i < 20000 && !irq; i++) @(negedge clk);
      if (!irq) chk({tag, " irq timeout"}, 0, 1);
   endtask

   // driver: expected byte goes to the scoreboard, then the transmit write
   task automatic send(input logic [7:0] b);
      exp_q.push_back(b);
      wr(3'd3, b);
   endtask

   always @(negedge clk) if (irq) irq_seen = 1'b1;

   // monitor: decodes the bus, acts as slave, stretches, pops the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (stretch_cnt > 0) begin
            stretch_cnt--;
            if (stretch_cnt == 0) stretch = 1'b0;
         end
         if (p_scl && scl_line && p_sda && !sda_line) begin starts++; bitcnt = 0; end
         if (p_scl && scl_line && !p_sda && sda_line) stops++;
         if (!p_scl && scl_line) begin
            if (last_rise >= 0) period_c = cyc - last_rise;
            last_rise = cyc;
            if (bitcnt < 8) rx_sh = {rx_sh[6:0], sda_line};
            bitcnt++;
            if (bitcnt == 8) begin
               if (exp_q.size() == 0) chk("R3 unexpected byte", {24'd0, rx_sh}, 32'hFFFF_FFFF);
               else chk("R3 byte on bus", {24'd0, rx_sh}, {24'd0, exp_q.pop_front()});
               bytes_seen++;
            end
         end
         if (p_scl && !scl_line) begin
            if (bitcnt == 8) slave_low = ack_en;
            else if (bitcnt == 9) begin slave_low = 1'b0; bitcnt = 0; end
            if (stretch_s > 0) begin stretch = 1'b1; stretch_cnt = 2*qlen + stretch_s; end
         end
         p_scl = scl_line;
         p_sda = sda_line;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk("RST scl_oe", scl_oe, 0);
      chk("RST sda_oe", sda_oe, 0);
      chk("RST irq", irq, 0);
      chk("RST busy", busy, 0);
      chk("RST flags", {start_seen, stop_seen, wcol}, 0);

      // R1: disabled, then enabled with a wrong mode code
      wr(3'd2, 8'd9);
      wr(3'd1, 8'h01);
      idle(60);
      chk("R1 disabled start", {busy, 31'(starts)}, 0);
      wr(3'd0, 8'h81);
      wr(3'd1, 8'h01);
      idle(60);
      chk("R1 wrong mode start", {busy, 31'(starts)}, 0);

      // R2: START
      wr(3'd0, 8'h88);
      wr(3'd1, 8'h01);
      chk("R2 start_pend during start", start_pend, 1);
      wait_irq("R2");
      chk("R2 start on bus", starts, 1);
      chk("R2 pend cleared, start_seen", {start_pend, start_seen, busy}, 3'b011);
      wr(3'd4, 8'h01);
      chk("R5 irq cleared by write", irq, 0);

      // R11: start while holding the bus
      wr(3'd1, 8'h01);
      idle(60);
      chk("R11 restart ignored", {irq, 31'(starts)}, 1);

      // R3/R4/R7/R10: acknowledged byte with a collision write mid-byte
      ack_en = 1'b1;
      send(8'hA5);
      idle(30);
      wr(3'd3, 8'hFF);
      chk("R10 wcol set", wcol, 1);
      wait_irq("R3");
      chk("R4 ack gives 0", ack_nak, 0);
      chk("R7 period D=9", period_c, 40);
      chk("R10 byte count", bytes_seen, 1);
      wr(3'd4, 8'h03);
      chk("R10 wcol cleared", {wcol, irq}, 0);

      // R5: clear held on the port through a whole byte, set must win
      ack_en = 1'b0;
      irq_seen = 1'b0;
      send(8'h3C);
      @(negedge clk); reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
      for (int i = 0; i < 5000 && !irq_seen; i++) @(negedge clk);
      reg_we = 1'b0;
      chk("R5 set wins over clear", irq_seen, 1);
      idle(2);
      chk("R5 cleared afterwards", irq, 0);
      chk("R4 no ack gives 1", ack_nak, 1);

      // R7: bit 7 of the divisor ignored; R11: stop during a byte ignored
      ack_en = 1'b1;
      wr(3'd2, 8'd200);
      qlen = 73;
      send(8'h81);
      idle(100);
      wr(3'd1, 8'h04);
      wait_irq("R7");
      chk("R7 period D=72", period_c, 292);
      wr(3'd4, 8'h01);
      idle(20);
      chk("R11 stop mid-byte ignored", {busy, stop_seen, 30'(stops)}, 32'h8000_0000);

      // R8: divisor 1 floors to 3
      wr(3'd2, 8'd1);
      qlen = 4;
      send(8'h5A);
      wait_irq("R8");
      chk("R8 floored period", period_c, 16);
      wr(3'd4, 8'h01);

      // R9: clock stretching by 7 cycles
      wr(3'd2, 8'd9);
      qlen = 10;
      stretch_s = 7;
      send(8'hC3);
      wait_irq("R9");
      chk("R9 stretched period", period_c, 47);
      stretch_s = 0;
      wr(3'd4, 8'h01);
      idle(60);

      // R6: STOP
      wr(3'd1, 8'h04);
      chk("R6 stop_pend", stop_pend, 1);
      wait_irq("R6");
      chk("R6 stop on bus", stops, 1);
      chk("R6 flags after stop", {stop_seen, start_seen, busy}, 3'b100);
      chk("R6 lines released", {scl_oe, sda_oe}, 0);
      wr(3'd4, 8'h01);

      // R11: transmit write while idle
      wr(3'd3, 8'h77);
      idle(60);
      chk("R11 tx in idle ignored", {busy, wcol, 30'(bytes_seen)}, 5);
      chk("R3 scoreboard drained", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule